// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is a serial slave that sits inside a programmable-logic design and accepts fixed-length command words from a host controller over a three-wire serial link: clock, data in and an active-low select. All three pins are brought into the local system clock domain through synchronizer chains. Edges of the serial clock are then found by oversampling, so the block contains no logic clocked by the serial clock. Each select-low window carries exactly one 16-bit word, sent most significant bit first. The upper four bits are an operation code and the lower twelve bits are an argument.

When the select line returns high after exactly sixteen captured bits, the block presents the operation code and argument on its outputs together with a one-cycle valid strobe. A window that closed after any other bit count is dropped silently. One operation code is decoded locally: it copies the low eight argument bits into a mode register, which drives the rest of the design. Every other code only produces the strobe and leaves the decoding to downstream logic.

Top module: `spi_cmd_rx`

## Requirements
- R1: A word is 16 bits sent most significant bit first; bits 15..12 appear on `cmd_o` and bits 11..0 on `data_o`.
- R2: Data is captured on the rising serial clock edge (clock idles low). The level of `spi_mosi` around the falling edge has no effect on the captured word.
- R3: When `spi_cs_n` rises after exactly 16 captured bits, `word_valid_o` is high for exactly one system clock cycle, within 10 cycles of the rise. `cmd_o` and `data_o` change only in that cycle.
- R4: When `spi_cs_n` rises after fewer than 16 captured bits, no strobe is produced, and `cmd_o`, `data_o` and `cfg_o` keep their values.
- R5: When `spi_cs_n` rises after more than 16 captured bits, no strobe is produced, and `cmd_o`, `data_o` and `cfg_o` keep their values.
- R6: A valid word whose command is 4'h1 loads `data_o[7:0]` into `cfg_o` on the cycle after the strobe.
- R7: A valid word with any command other than 4'h1 raises the strobe and leaves `cfg_o` unchanged.
- R8: While `rst` is high, and on the cycle after it, `word_valid_o`, `cmd_o`, `data_o` and `cfg_o` are all zero.
- R9: Serial clock edges while `spi_cs_n` is high are ignored. Each select-low window starts counting bits from zero.
- R10: Words are received correctly when each serial clock phase lasts at least 3 system clock cycles. At 50 MHz this covers a 4 MHz serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low, asynchronous to `clk` |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low select; one word per low window |
| cmd_o | output | 4 | Operation code of the last accepted word |
| data_o | output | 12 | Argument of the last accepted word |
| word_valid_o | output | 1 | One-cycle strobe when a word is accepted |
| cfg_o | output | 8 | Mode register, loaded by command 4'h1 |

## Verification
Words are sent with patterns that tell bit order and field split apart: mixed values such as 16'h10A5 and 16'h3F0F, and the all-ones and all-zeros extremes. Windows of 15 and 17 bits check that bad framing is discarded. For the 17-bit case, the first sixteen bits would themselves make a valid configuration load, so a truncating receiver would be exposed. In one run the data line is flipped to the wrong value while the serial clock is high, which separates rising-edge capture from falling-edge capture. Further runs send clock pulses with the select line inactive, and words at the fastest supported phase length. Together these confirm that stray clocks and a minimal sampling margin do not corrupt a word.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int WORD_BITS   = 16;
    localparam int OP_BITS     = 4;
    localparam int ARG_BITS    = WORD_BITS - OP_BITS;
    localparam int CFG_BITS    = 8;
    localparam int SYNC_STAGES = 2;

    // bit counter saturates one past a full word so overlong frames are seen
    localparam int CNT_W = $clog2(WORD_BITS + 2);

    typedef struct packed {
        logic [OP_BITS-1:0]  op;
        logic [ARG_BITS-1:0] arg;
    } cmd_word_t;

    localparam logic [OP_BITS-1:0] OP_SET_CFG = 4'h1;

    function automatic cmd_word_t split_word(input logic [WORD_BITS-1:0] w);
        return cmd_word_t'(w);
    endfunction

    function automatic logic is_cfg_op(input logic [OP_BITS-1:0] op);
        return op == OP_SET_CFG;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RESET_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import spi_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_rise,
    input  logic                 sel_active,
    input  logic                 sel_start,
    input  logic                 sel_end,
    input  logic                 mosi_bit,
    output logic                 frame_done,
    output logic [WORD_BITS-1:0] frame_bits
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_BITS + 1);

    logic [WORD_BITS-1:0] shreg;
    logic [CNT_W-1:0]     nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            nbits <= '0;
        end else if (sel_start) begin
            nbits <= '0;
        end else if (sck_rise && sel_active) begin
            shreg <= {shreg[WORD_BITS-2:0], mosi_bit};
            if (nbits != OVER) nbits <= nbits + 1'b1;
        end
    end

    assign frame_done = sel_end && (nbits == FULL);
    assign frame_bits = shreg;
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import spi_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_done,
    input  logic [WORD_BITS-1:0] frame_bits,
    output logic [OP_BITS-1:0]   cmd,
    output logic [ARG_BITS-1:0]  arg,
    output logic                 valid,
    output logic [CFG_BITS-1:0]  cfg
);
    cmd_word_t word_q;
    logic      valid_q;
    logic [CFG_BITS-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= frame_done;
            if (frame_done) word_q <= split_word(frame_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (valid_q && is_cfg_op(word_q.op)) begin
            cfg_q <= word_q.arg[CFG_BITS-1:0];
        end
    end

    assign cmd   = word_q.op;
    assign arg   = word_q.arg;
    assign valid = valid_q;
    assign cfg   = cfg_q;
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
    import spi_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    input  logic                spi_cs_n,
    output logic [OP_BITS-1:0]  cmd_o,
    output logic [ARG_BITS-1:0] data_o,
    output logic                word_valid_o,
    output logic [CFG_BITS-1:0] cfg_o
);
    logic sck_lvl, sck_rise, sck_fall;
    logic mosi_lvl, mosi_rise, mosi_fall;
    logic cs_lvl, cs_rise, cs_fall;
    logic frame_done;
    logic [WORD_BITS-1:0] frame_bits;

    pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .pin(spi_sck),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_mosi_sync (
        .clk(clk), .rst(rst), .pin(spi_mosi),
        .level(mosi_lvl), .rise(mosi_rise), .fall(mosi_fall)
    );

    pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .pin(spi_cs_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    frame_shifter u_shift (
        .clk(clk), .rst(rst),
        .sck_rise(sck_rise), .sel_active(~cs_lvl),
        .sel_start(cs_fall), .sel_end(cs_rise),
        .mosi_bit(mosi_lvl),
        .frame_done(frame_done), .frame_bits(frame_bits)
    );

    cmd_decode u_dec (
        .clk(clk), .rst(rst),
        .frame_done(frame_done), .frame_bits(frame_bits),
        .cmd(cmd_o), .arg(data_o), .valid(word_valid_o), .cfg(cfg_o)
    );

    // level/edge outputs not needed for every pin
    logic unused_ok;
    assign unused_ok = &{1'b0, sck_lvl, sck_fall, mosi_rise, mosi_fall};
endmodule

// File: rtl/spi_cmd_rx_checker.sv
module spi_cmd_rx_checker
    import spi_cmd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [OP_BITS-1:0]  cmd_o,
    input logic [ARG_BITS-1:0] data_o,
    input logic                word_valid_o,
    input logic [CFG_BITS-1:0] cfg_o
);
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    assert_fields_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !word_valid_o |=> (word_valid_o || ($stable(cmd_o) && $stable(data_o))));

    assert_cfg_load_R6: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && cmd_o == OP_SET_CFG) |=> (cfg_o == $past(data_o[CFG_BITS-1:0])));

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(word_valid_o && cmd_o == OP_SET_CFG) |=> $stable(cfg_o));

    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (!word_valid_o && cmd_o == '0 && data_o == '0 && cfg_o == '0));
endmodule

bind spi_cmd_rx spi_cmd_rx_checker u_chk (
    .clk(clk), .rst(rst), .cmd_o(cmd_o), .data_o(data_o),
    .word_valid_o(word_valid_o), .cfg_o(cfg_o)
);

// File: tb/spi_cmd_rx_test.sv
module spi_cmd_rx_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic cs_n = 1'b1;
    logic [3:0]  cmd_o;
    logic [11:0] data_o;
    logic        word_valid_o;
    logic [7:0]  cfg_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] exp_cfg = 8'h00;
    logic [3:0] exp_cmd = 4'h0;
    logic [11:0] exp_data = 12'h000;

    always #10 clk = ~clk;

    spi_cmd_rx uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .cmd_o(cmd_o), .data_o(data_o), .word_valid_o(word_valid_o), .cfg_o(cfg_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one select window of n bits, MSB first; count strobes afterwards
    task automatic send_frame(input logic [31:0] bits, input int n, input int half,
                              input bit glitch, output int pulses);
        pulses = 0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_cyc(half);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = bits[i];
            wait_cyc(half);
            sck = 1'b1;
            if (glitch) begin
                wait_cyc(2);
                mosi = ~bits[i];
                wait_cyc(half - 2);
            end else begin
                wait_cyc(half);
            end
            sck = 1'b0;
        end
        wait_cyc(half);
        cs_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (word_valid_o) pulses++;
        end
    endtask

    task automatic check_outputs(input string req);
        chk({req, " cmd"}, cmd_o, exp_cmd);
        chk({req, " data"}, data_o, exp_data);
        chk({req, " cfg"}, cfg_o, exp_cfg);
    endtask

    task automatic good_word(input string req, input logic [15:0] w, input int half, input bit glitch);
        int p;
        send_frame({16'h0, w}, 16, half, glitch, p);
        chk({req, " pulses"}, p, 1);
        exp_cmd  = w[15:12];
        exp_data = w[11:0];
        if (w[15:12] == 4'h1) exp_cfg = w[7:0];
        check_outputs(req);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R8 valid", word_valid_o, 0);
        check_outputs("R8");
        rst = 1'b0;
        wait_cyc(5);
        chk("R8 valid after release", word_valid_o, 0);
    endtask

    task automatic t_cfg_word;
        good_word("R1 R3 R6 cfg word", 16'h10A5, 6, 0);
    endtask

    task automatic t_other_cmd;
        good_word("R1 R7 other cmd", 16'h3F0F, 6, 0);
    endtask

    task automatic t_short;
        int p;
        send_frame(32'h0000_0ABC, 15, 6, 0, p);
        chk("R4 short pulses", p, 0);
        check_outputs("R4 short");
    endtask

    task automatic t_long;
        int p;
        send_frame({15'h0, 16'h1077, 1'b1}, 17, 6, 0, p);
        chk("R5 long pulses", p, 0);
        check_outputs("R5 long");
    endtask

    task automatic t_glitch;
        good_word("R2 falling-edge data", 16'h11C3, 6, 1);
    endtask

    task automatic t_idle_clocks;
        @(negedge clk);
        mosi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sck = 1'b1;
            wait_cyc(6);
            sck = 1'b0;
            wait_cyc(6);
        end
        chk("R9 no strobe while idle", word_valid_o, 0);
        good_word("R9 after idle clocks", 16'hE001, 6, 0);
    endtask

    task automatic t_fast;
        good_word("R10 fast clock", 16'h1555, 3, 0);
        good_word("R10 fast other", 16'h2AAA, 3, 0);
    endtask

    task automatic t_extremes;
        good_word("R1 all ones", 16'hFFFF, 6, 0);
        good_word("R1 all zeros", 16'h0000, 6, 0);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        t_cfg_word();
        t_other_cmd();
        t_short();
        t_long();
        t_glitch();
        t_idle_clocks();
        t_fast();
        t_extremes();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule